// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small in-order core and decides, at each instruction boundary, whether the core should divert to an interrupt handler and which handler to enter. It accepts two kinds of source. Latched sources capture a one-cycle event into a pending flag that survives until it is serviced or cleared by software. Level sources have no storage and request only while their input is high. Every source is masked by its own enable bit, and a single global enable gates them all.

When a request is accepted, the controller pulses its request output for one cycle. At the same time it presents the vector number of the winning source and clears the global enable. For a latched source it also pulses that source's bit on the acknowledge-clear output. Vector 0 is reserved for reset, so source `i` is reported as vector `i+1`, and a lower vector always wins. After a return from interrupt, the controller lets exactly one main-program instruction retire before it accepts another request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `irq`, `irq_vec`, `ack_clr` and `gie` are all zero, and no latched source is pending.
- R2: A source is taken only when its bit in `src_en` and the global enable `gie` are both one.
- R3: When several enabled sources request together, the one with the lowest index is taken. `irq_vec` carries the binary value index+1, which lies in 1..NUM_SRC. `irq_vec` is zero whenever `irq` is low.
- R4: A take decided in a cycle with `retire` high raises `irq` for exactly one cycle, starting at the following clock edge. `gie` reads zero in that same cycle.
- R5: `reti` or `gie_set` sets `gie` at the next edge. `gie_clr` clears it and overrides both. Taking an interrupt also clears it, and that clear overrides `gie_set`.
- R6: For a latched source, taking it clears its pending flag and pulses its bit of `ack_clr` together with `irq`. Writing a one to its bit of `flag_wr_clr` also clears the pending flag.
- R7: A latched event that arrives while its enable or `gie` is off stays pending. It is served once both enables are on.
- R8: A level source (bit set in `LEVEL_MASK`, sources 2 and 7 by default) requests only while its `src_evt` bit is high. Dropping the input before it is enabled leaves nothing pending. Its `ack_clr` bit never pulses.
- R9: No interrupt is taken in a cycle where `reti` is high, nor at the first `retire` after a `reti`.
- R10: `gie_clr` blocks a take in the same cycle it is asserted.
- R11: An event and a software clear of the same flag in one cycle leave the flag pending.
- R12: No interrupt is taken in a cycle where `retire` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | NUM_SRC | Event pulses (latched sources) or condition levels (level sources) |
| src_en | input | NUM_SRC | Per-source enable |
| flag_wr_clr | input | NUM_SRC | Software write-one-to-clear of pending flags |
| gie_set | input | 1 | Software set of the global enable |
| gie_clr | input | 1 | Software clear of the global enable |
| retire | input | 1 | Instruction-boundary strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | One-cycle interrupt-taken pulse |
| irq_vec | output | VEC_W | Vector number of the taken source (index+1) |
| ack_clr | output | NUM_SRC | One-hot flag clear for a taken latched source |
| gie | output | 1 | Current global enable |

## Verification
Directed sequences cover each corner case in turn:
- two simultaneous latched events, to separate lowest-index arbitration from arrival order;
- a return followed by back-to-back boundaries, to show the one-instruction hold;
- a level source that drops before it is enabled, to show it leaves nothing behind;
- an event that coincides with its own software clear.

Seeded random traffic then mixes sparse events, enable patterns, strobes and clears. This exposes interactions between global-enable priority, pending retention and the hold after return. Each cycle's outputs are compared against a requirement-level model in the bench.

// File: rtl/irq_pkg.sv
// Package: shared types for the vectored interrupt controller.
// Assumes nothing beyond being compiled ahead of its users.
package irq_pkg;
    // Kind of an interrupt source: latched event flag or bare level.
    typedef enum logic {
        SRC_FLAG  = 1'b0,
        SRC_LEVEL = 1'b1
    } src_kind_e;
endpackage

// File: rtl/irq_src_slot.sv
// One interrupt source slot. A latched slot keeps a pending flag that is
// set by an event and cleared by software or by the take. The event wins
// over a same-cycle clear. A level slot stores nothing and forwards its
// condition. Assumes a synchronous active-low reset.
module irq_src_slot #(
    parameter irq_pkg::src_kind_e KIND = irq_pkg::SRC_FLAG
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic en,
    input  logic sw_clr,
    input  logic take_clr,
    output logic req
);
    generate
        if (KIND == irq_pkg::SRC_FLAG) begin : g_flag
            logic pend_q;
            // Pending flag: the event has priority over both kinds of clear.
            always_ff @(posedge clk) begin
                if (!rst_n) pend_q <= 1'b0;
                else        pend_q <= (pend_q & ~sw_clr & ~take_clr) | evt;
            end
            assign req = pend_q & en;
        end else begin : g_level
            logic unused_lvl;
            // Level source ignores clock and clears; the request follows the input.
            assign unused_lvl = ^{clk, rst_n, sw_clr, take_clr};
            assign req = evt & en;
        end
    endgenerate
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: the lowest set request index wins.
// Produces the winner as a binary index and as a one-hot mask.
// Assumes NUM_SRC >= 2.
module irq_prio_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   win_idx,
    output logic [NUM_SRC-1:0] win_oh
);
    // Scan from the top down so the lowest set index is written last.
    always_comb begin
        win_idx = '0;
        win_oh  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win_idx = IDX_W'(i);
                win_oh  = '0;
                win_oh[i] = 1'b1;
            end
        end
    end

    assign any = |req;
endmodule

// File: rtl/irq_gate_ctl.sv
// Global-enable and boundary control. Decides whether a request may be
// taken in this cycle. It owns the global enable and the one-instruction
// hold that follows a return. Assumes retire and reti are one-cycle strobes.
module irq_gate_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic retire,
    input  logic reti,
    input  logic gie_set,
    input  logic gie_clr,
    input  logic any_req,
    output logic take,
    output logic gie
);
    logic gie_q;
    logic hold_q;

    // Take only at a boundary that is not a return and not the held one,
    // with the enable on and not being cleared in the same cycle.
    assign take = retire & ~reti & ~hold_q & gie_q & ~gie_clr & any_req;

    // Global enable: the take or a software clear beat any set.
    always_ff @(posedge clk) begin
        if (!rst_n)                 gie_q <= 1'b0;
        else if (take || gie_clr)   gie_q <= 1'b0;
        else if (reti || gie_set)   gie_q <= 1'b1;
    end

    // Hold: armed by a return and released by the next retired instruction.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (reti)   hold_q <= 1'b1;
        else if (retire) hold_q <= 1'b0;
    end

    assign gie = gie_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
// Vectored priority interrupt controller top. Builds one slot per source
// (latched or level, chosen by LEVEL_MASK), picks the lowest enabled
// request and gates it at instruction boundaries. The outcome is
// registered as irq, irq_vec and ack_clr. Vector 0 is reserved, so source
// i reports i+1. Assumes a synchronous active-low reset.
module prio_irq_ctrl #(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'b1000_0100,
    localparam int IDX_W = $clog2(NUM_SRC),
    localparam int VEC_W = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] flag_wr_clr,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               retire,
    input  logic               reti,
    output logic               irq,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NUM_SRC-1:0] ack_clr,
    output logic               gie
);
    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] win_oh;
    logic [IDX_W-1:0]   win_idx;
    logic               any_req;
    logic               take;

    // One slot per source, of the kind that LEVEL_MASK selects.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        irq_src_slot #(
            .KIND(LEVEL_MASK[i] ? irq_pkg::SRC_LEVEL : irq_pkg::SRC_FLAG)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (src_evt[i]),
            .en       (src_en[i]),
            .sw_clr   (flag_wr_clr[i]),
            .take_clr (take & win_oh[i]),
            .req      (req[i])
        );
    end

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .req     (req),
        .any     (any_req),
        .win_idx (win_idx),
        .win_oh  (win_oh)
    );

    irq_gate_ctl u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .retire  (retire),
        .reti    (reti),
        .gie_set (gie_set),
        .gie_clr (gie_clr),
        .any_req (any_req),
        .take    (take),
        .gie     (gie)
    );

    // Register the take: a one-cycle pulse, its vector and the flag acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            irq_vec <= '0;
            ack_clr <= '0;
        end else begin
            irq     <= take;
            irq_vec <= take ? VEC_W'(win_idx) + VEC_W'(1) : '0;
            ack_clr <= take ? (win_oh & ~LEVEL_MASK) : '0;
        end
    end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Property checker for prio_irq_ctrl, attached by bind. Watches the ports
// only and assumes the synchronous active-low reset of the design.
module prio_irq_ctrl_chk #(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'b1000_0100,
    localparam int VEC_W = $clog2(NUM_SRC + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               gie_clr,
    input logic               retire,
    input logic               reti,
    input logic               irq,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [NUM_SRC-1:0] ack_clr,
    input logic               gie
);
    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gie)); // R2
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_vec != '0 && int'(irq_vec) <= NUM_SRC)); // R3
    AST_VEC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> irq_vec == '0); // R3
    AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !gie); // R4
    AST_IRQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R4
    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !gie_clr) |=> gie); // R5
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_clr)); // R6
    AST_ACK_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_clr) |-> irq); // R6
    AST_LEVEL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr & LEVEL_MASK) == '0); // R8
    AST_NO_TAKE_ON_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> !irq); // R9
    AST_GIECLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        gie_clr |=> !irq); // R10
    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !retire |=> !irq); // R12
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .LEVEL_MASK(LEVEL_MASK)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gie_clr (gie_clr),
    .retire  (retire),
    .reti    (reti),
    .irq     (irq),
    .irq_vec (irq_vec),
    .ack_clr (ack_clr),
    .gie     (gie)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    localparam int N = 8;
    localparam int VW = $clog2(N + 1);
    localparam logic [N-1:0] LVL = 8'b1000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] src_evt = '0, src_en = '1, flag_wr_clr = '0;
    logic gie_set = 0, gie_clr = 0, retire = 0, reti = 0;
    logic irq;
    logic [VW-1:0] irq_vec;
    logic [N-1:0] ack_clr;
    logic gie;

    int total = 0, bad = 0;
    string tag = "R1";

    // Requirement-level model state.
    logic [N-1:0] m_flag = '0;
    logic m_gie = 0, m_hold = 0;
    logic e_irq = 0, e_gie = 0;
    logic [VW-1:0] e_vec = '0;
    logic [N-1:0] e_ack = '0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(N), .LEVEL_MASK(LVL)) u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_en(src_en),
        .flag_wr_clr(flag_wr_clr), .gie_set(gie_set), .gie_clr(gie_clr),
        .retire(retire), .reti(reti), .irq(irq), .irq_vec(irq_vec),
        .ack_clr(ack_clr), .gie(gie)
    );

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input logic ok, input string t, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", t, msg);
        end
    endtask

    // One clock: predict from the requirements, step, compare, clear strobes.
    task automatic cyc();
        logic [N-1:0] rq, oh;
        logic tk;
        int w;
        rq = ((src_evt & LVL) | (m_flag & ~LVL)) & src_en;
        w  = lowest(rq);
        tk = rst_n && retire && !reti && !m_hold && m_gie && !gie_clr && (w >= 0);
        oh = tk ? (N'(1) << w) : '0;
        @(posedge clk);
        #1;
        if (!rst_n) begin
            m_flag = '0; m_gie = 0; m_hold = 0;
            e_irq = 0; e_vec = '0; e_ack = '0;
        end else begin
            e_irq  = tk;
            e_vec  = tk ? VW'(w + 1) : '0;
            e_ack  = oh & ~LVL;
            m_flag = ((m_flag & ~flag_wr_clr & ~oh) | src_evt) & ~LVL;
            if (tk || gie_clr) m_gie = 0;
            else if (reti || gie_set) m_gie = 1;
            if (reti) m_hold = 1; else if (retire) m_hold = 0;
        end
        e_gie = m_gie;
        chk(irq === e_irq && irq_vec === e_vec && ack_clr === e_ack && gie === e_gie, tag,
            $sformatf("irq/vec/ack/gie act=%0b/%0d/%b/%0b exp=%0b/%0d/%b/%0b",
                      irq, irq_vec, ack_clr, gie, e_irq, e_vec, e_ack, e_gie));
        retire = 0; reti = 0; gie_set = 0; gie_clr = 0; flag_wr_clr = '0;
        src_evt = src_evt & LVL;
    endtask

    task automatic expect_take(input logic ei, input int ev, input string t);
        chk(irq === ei && int'(irq_vec) == ev, t,
            $sformatf("irq/vec act=%0b/%0d exp=%0b/%0d", irq, irq_vec, ei, ev));
    endtask

    initial begin
        #(5.0 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        // R1: reset values
        tag = "R1";
        cyc(); cyc(); cyc();
        rst_n = 1;
        cyc();
        chk(irq === 0 && irq_vec === '0 && ack_clr === '0 && gie === 0, "R1",
            $sformatf("reset outputs act=%0b/%0d/%b/%0b exp=0/0/0/0", irq, irq_vec, ack_clr, gie));
        // R5: software set
        tag = "R5"; gie_set = 1; cyc();
        chk(gie === 1, "R5", $sformatf("gie act=%0b exp=1", gie));
        // R3/R4/R6: two latched events together, lowest index wins
        tag = "R3"; src_evt = 8'b0010_1000; cyc();
        retire = 1; cyc();
        expect_take(1, 4, "R3");
        chk(gie === 0, "R4", $sformatf("gie on entry act=%0b exp=0", gie));
        chk(ack_clr === 8'b0000_1000, "R6", $sformatf("ack act=%b exp=00001000", ack_clr));
        cyc(); expect_take(0, 0, "R4");
        // R9: hold one instruction after return
        tag = "R9"; reti = 1; retire = 1; cyc(); expect_take(0, 0, "R9");
        retire = 1; cyc(); expect_take(0, 0, "R9");
        retire = 1; cyc(); expect_take(1, 6, "R9");
        // R7/R2: pending while disabled, served once enabled
        tag = "R7"; src_en[1] = 0; src_evt[1] = 1; cyc();
        gie_set = 1; cyc(); retire = 1; cyc(); expect_take(0, 0, "R2");
        src_en[1] = 1; retire = 1; cyc(); expect_take(1, 2, "R7");
        // R8: level source dropped before enable leaves nothing
        tag = "R8"; src_en[2] = 0; src_evt[2] = 1; gie_set = 1; cyc();
        src_evt[2] = 0; cyc();
        src_en[2] = 1; retire = 1; cyc(); expect_take(0, 0, "R8");
        src_evt[2] = 1; retire = 1; cyc(); expect_take(1, 3, "R8");
        chk(ack_clr === '0, "R8", $sformatf("level ack act=%b exp=0", ack_clr));
        src_evt[2] = 0; cyc();
        // R10: clear in the boundary cycle blocks the take
        tag = "R10"; gie_set = 1; src_evt[0] = 1; cyc();
        retire = 1; gie_clr = 1; cyc(); expect_take(0, 0, "R10");
        gie_set = 1; cyc(); retire = 1; cyc(); expect_take(1, 1, "R10");
        // R6: taken flag gone; software clear removes a pending flag
        tag = "R6"; gie_set = 1; cyc(); retire = 1; cyc(); expect_take(0, 0, "R6");
        src_evt[4] = 1; cyc(); flag_wr_clr[4] = 1; cyc();
        retire = 1; cyc(); expect_take(0, 0, "R6");
        // R11: event and clear together keep the flag
        tag = "R11"; src_evt[6] = 1; flag_wr_clr[6] = 1; cyc();
        retire = 1; cyc(); expect_take(1, 7, "R11");
        // R12: no boundary, no take
        tag = "R12"; src_evt[5] = 1; gie_set = 1; cyc();
        for (int k = 0; k < 4; k++) begin cyc(); expect_take(0, 0, "R12"); end
        retire = 1; cyc(); expect_take(1, 6, "R12");
        // Random mix checked against the model (R2 R3 R5 R6 R7 R9 R10)
        tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            src_evt     = N'($urandom & $urandom & $urandom);
            src_en      = N'($urandom | $urandom);
            flag_wr_clr = N'($urandom & $urandom & $urandom);
            retire      = $urandom_range(0, 1) == 1;
            reti        = $urandom_range(0, 15) == 0;
            gie_set     = $urandom_range(0, 5) == 0;
            gie_clr     = $urandom_range(0, 19) == 0;
            cyc();
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule